// File: doc/BRIEF.md
# USB Line-State Event Detector

This block watches the two USB data lines, turns every sample into one of four bus states, and measures how long the current state has lasted. When a state has lasted long enough, the block raises a single-cycle pulse. There are three such pulses: resume, idle and peripheral attach. The pulses are meant to set bits in an interrupt flag register next to the block. Both data lines pass through a synchroniser before they are decoded. Every duration count is derived from a clock-frequency parameter.

The block uses two thresholds. A resume pulse needs a K state held for 2.5 µs, and only while resume detection is enabled; that enable is normally set only while the port is suspended. An idle pulse needs J held for 3 ms. An attach pulse needs three things: host mode, a bus quiet for 2.5 µs, and a line that is not SE0.

Every change of the decoded line state counts as bus activity and restarts all three duration counts. Each qualifying period produces at most one pulse.

Top module: `usb_line_event_detector`

## Requirements
- R1: The bits {D+, D-} decode to a line state as follows: 10 is J, 01 is K, 00 is SE0 and 11 is SE1. Only J can produce an idle pulse, only K can produce a resume pulse, and SE0 never produces an attach pulse.
- R2: Both thresholds are derived from the parameter CLK_HZ. The short threshold is T_S = CLK_HZ·2.5 µs, which is CLK_HZ/400000 cycles. The long threshold is T_L = CLK_HZ·3 ms, which is CLK_HZ·3/1000 cycles.
- R3: Suppose a line change starts a K period while resume_en_i is high. Then evt_resume_o is high in exactly one cycle, T_S+3 rising edges after the change. The extra 3 edges are two synchroniser stages plus one state register.
- R4: While resume_en_i is low, a K period of any length produces no resume pulse.
- R5: A J period that lasts T_L cycles produces exactly one evt_idle_o pulse, T_L+3 rising edges after the line change.
- R6: With host_en_i high, a line change into J, K or SE1 produces one evt_attach_o pulse T_S+3 edges later. If host_en_i rises while the line already holds a stable non-SE0 state, the pulse comes T_S edges after that rise, because host_en_i is used directly.
- R7: No attach pulse is produced while host_en_i is low or while the line is SE0.
- R8: Any change of the decoded line state restarts all duration counts. A K period shorter than T_S therefore yields no resume pulse. A change between two non-SE0 states delays the attach pulse until T_S+3 edges after the later change.
- R9: Each event fires at most once per qualifying period. It does not fire again, however long the state is held, until a new period begins.
- R10: While rst_n is low, all outputs are low. After rst_n is released, the line is treated as if it had just changed from SE0, so a K held through reset yields a resume pulse T_S+3 edges after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | Raw D+ line |
| dm_i | input | 1 | Raw D- line |
| host_en_i | input | 1 | Host mode enable; gates attach detection |
| resume_en_i | input | 1 | Resume detection enable, normally set while suspended |
| evt_resume_o | output | 1 | One-cycle resume pulse |
| evt_idle_o | output | 1 | One-cycle idle pulse |
| evt_attach_o | output | 1 | One-cycle peripheral attach pulse |

## Verification
The hardest case to reach from the ports is proving that a line change really restarts a count. For the resume and idle counts, the state change also removes the qualifying condition, so a missing restart would go unnoticed.

The attach count is different, because it keeps running across J, K and SE1. The stimulus therefore holds J briefly in host mode and then switches to K. The attach pulse must then land exactly T_S+3 edges after the K change, not earlier. The same exact-offset check is also applied across a reset taken in the middle of a K period.

// File: rtl/usb_lse_pkg.sv
package usb_lse_pkg;

  // Line state encoding equals the synchronised {D+, D-} pair.
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10,
    LS_SE1 = 2'b11
  } line_state_t;

  localparam int NUM_EV    = 3;
  localparam int EV_RESUME = 0;
  localparam int EV_IDLE   = 1;
  localparam int EV_ATTACH = 2;

  // Cycles of a clock at clk_hz that fit in ns nanoseconds, at least one.
  function automatic int unsigned cycles_from_ns(longint unsigned clk_hz,
                                                 longint unsigned ns);
    longint unsigned q;
    q = (clk_hz * ns) / 64'd1_000_000_000;
    if (q == 64'd0) q = 64'd1;
    return q[31:0];
  endfunction

  // Counter width able to hold the value lim.
  function automatic int unsigned count_width(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/usb_lse_sync.sv
module usb_lse_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/usb_lse_decode.sv
module usb_lse_decode
  import usb_lse_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  lines_i,    // {D+, D-} after synchronisation
  output line_state_t state_o,
  output logic        activity_o
);

  line_state_t prev_q;

  assign state_o    = line_state_t'(lines_i);
  assign activity_o = (state_o != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= LS_SE0;
    else        prev_q <= state_o;
  end

endmodule

// File: rtl/usb_lse_timer.sv
module usb_lse_timer
  import usb_lse_pkg::*;
#(
  parameter int unsigned LIMIT = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic hit_o
);

  localparam int unsigned    CW   = count_width(LIMIT);
  localparam logic [CW-1:0]  FULL = CW'(LIMIT);
  localparam logic [CW-1:0]  LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // Saturating count of qualifying cycles since the last restart.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != FULL) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign hit_o = run_i && !restart_i && (cnt_q == LAST);

endmodule

// File: rtl/usb_line_event_detector.sv
module usb_line_event_detector
  import usb_lse_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 12_000_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_i,
  input  logic dm_i,
  input  logic host_en_i,
  input  logic resume_en_i,
  output logic evt_resume_o,
  output logic evt_idle_o,
  output logic evt_attach_o
);

  localparam int unsigned SHORT_CYC = cycles_from_ns(CLK_HZ, 2_500);
  localparam int unsigned LONG_CYC  = cycles_from_ns(CLK_HZ, 3_000_000);

  function automatic int unsigned limit_for(int idx);
    case (idx)
      EV_IDLE: return LONG_CYC;
      default: return SHORT_CYC;
    endcase
  endfunction

  logic [1:0]        lines_sync;
  line_state_t       line_state;
  logic              activity;
  logic [NUM_EV-1:0] ev_run;
  logic [NUM_EV-1:0] ev_hit;
  logic [NUM_EV-1:0] evt_q;

  usb_lse_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({dp_i, dm_i}),
    .q_o   (lines_sync)
  );

  usb_lse_decode u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .lines_i    (lines_sync),
    .state_o    (line_state),
    .activity_o (activity)
  );

  always_comb begin
    ev_run[EV_RESUME] = (line_state == LS_K) && resume_en_i;
    ev_run[EV_IDLE]   = (line_state == LS_J);
    ev_run[EV_ATTACH] = host_en_i && (line_state != LS_SE0);
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_timer
    usb_lse_timer #(.LIMIT(limit_for(g))) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (activity),
      .run_i     (ev_run[g]),
      .hit_o     (ev_hit[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= ev_hit;
  end

  assign evt_resume_o = evt_q[EV_RESUME];
  assign evt_idle_o   = evt_q[EV_IDLE];
  assign evt_attach_o = evt_q[EV_ATTACH];

endmodule

// File: rtl/usb_lse_checker.sv
module usb_lse_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       host_en,
  input logic       resume_en,
  input logic [1:0] line_state,
  input logic       activity,
  input logic       evt_resume,
  input logic       evt_idle,
  input logic       evt_attach
);

  AST_RESUME_ON_K: assert property (@(posedge clk) disable iff (!rst_n)
    evt_resume |-> $past(line_state == 2'b01)); // R3
  AST_RESUME_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_resume |-> $past(resume_en)); // R4
  AST_IDLE_ON_J: assert property (@(posedge clk) disable iff (!rst_n)
    evt_idle |-> $past(line_state == 2'b10)); // R5
  AST_ATTACH_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    evt_attach |-> $past(host_en)); // R6
  AST_ATTACH_NOT_SE0: assert property (@(posedge clk) disable iff (!rst_n)
    evt_attach |-> $past(line_state != 2'b00)); // R7
  AST_ACTIVITY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !(evt_resume || evt_idle || evt_attach)); // R8
  AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_resume |=> !evt_resume); // R9
  AST_IDLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_idle |=> !evt_idle); // R9
  AST_ATTACH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_attach |=> !evt_attach); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !(evt_resume || evt_idle || evt_attach)); // R10

endmodule

bind usb_line_event_detector usb_lse_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_en    (host_en_i),
  .resume_en  (resume_en_i),
  .line_state (line_state),
  .activity   (activity),
  .evt_resume (evt_resume_o),
  .evt_idle   (evt_idle_o),
  .evt_attach (evt_attach_o)
);

// File: tb/test_usb_line_event_detector.sv
module test_usb_line_event_detector;

  localparam int unsigned CLK_HZ = 4_000_000;
  // Thresholds restated from the requirements (R2).
  localparam int unsigned TS  = CLK_HZ / 400_000;     // 2.5 us
  localparam int unsigned TL  = CLK_HZ * 3 / 1000;    // 3 ms
  localparam int unsigned LAT = 3;                    // 2 sync stages + state register

  typedef struct packed {
    logic        dp;
    logic        dm;
    logic        host;
    logic        resen;
    int unsigned hold;
    int unsigned off_res;   // 0 = no pulse expected
    int unsigned off_idle;
    int unsigned off_att;
    int unsigned req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, TL + 20, 0, TL + LAT, 0, 5},   // R5 J held 3 ms, R1 J code
    '{1'b0, 1'b1, 1'b0, 1'b1, 40, TS + LAT, 0, 0, 3},        // R3 K with enable, R1 K code
    '{1'b1, 1'b0, 1'b0, 1'b1, 5, 0, 0, 0, 8},                // R8 short J
    '{1'b0, 1'b1, 1'b0, 1'b1, 8, 0, 0, 0, 8},                // R8 K too short
    '{1'b1, 1'b0, 1'b0, 1'b0, TL + 20, 0, TL + LAT, 0, 9},   // R9 new J period fires again
    '{1'b0, 1'b1, 1'b0, 1'b0, 40, 0, 0, 0, 4},               // R4 K without enable
    '{1'b0, 1'b0, 1'b1, 1'b0, 40, 0, 0, 0, 7},               // R7 SE0 in host mode
    '{1'b1, 1'b1, 1'b1, 1'b0, 40, 0, 0, TS + LAT, 6},        // R6 SE1 attach, R1 SE1 code
    '{1'b0, 1'b1, 1'b1, 1'b1, 40, TS + LAT, 0, TS + LAT, 6}, // R6 K attach plus resume
    '{1'b1, 1'b0, 1'b1, 1'b0, 5, 0, 0, 0, 8},                // R8 brief J in host mode
    '{1'b0, 1'b1, 1'b1, 1'b0, 40, 0, 0, TS + LAT, 8},        // R8 attach counted from K change
    '{1'b1, 1'b0, 1'b0, 1'b0, 40, 0, 0, 0, 7},               // R7 host disabled
    '{1'b1, 1'b0, 1'b1, 1'b0, 40, 0, 0, TS, 6},              // R6 host_en rises on stable J
    '{1'b1, 1'b0, 1'b1, 1'b0, 3 * TS, 0, 0, 0, 9}            // R9 no repeat
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b0, dm = 1'b0, host_en = 1'b0, resume_en = 1'b0;
  logic evt_resume, evt_idle, evt_attach;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  usb_line_event_detector #(.CLK_HZ(CLK_HZ)) i_usb_line_event_detector (
    .clk          (clk),
    .rst_n        (rst_n),
    .dp_i         (dp),
    .dm_i         (dm),
    .host_en_i    (host_en),
    .resume_en_i  (resume_en),
    .evt_resume_o (evt_resume),
    .evt_idle_o   (evt_idle),
    .evt_attach_o (evt_attach)
  );

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Hold the current inputs for n cycles, counting pulses and the first offset.
  task automatic observe(input int n, input int start,
                         output int cnt [3], output int first [3]);
    logic [2:0] ev;
    for (int e = 0; e < 3; e++) begin cnt[e] = 0; first[e] = 0; end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ev = {evt_attach, evt_idle, evt_resume};
      for (int e = 0; e < 3; e++) begin
        if (ev[e]) begin
          cnt[e]++;
          if (cnt[e] == 1) first[e] = cyc - start;
        end
      end
    end
  endtask

  task automatic judge(input int req, input string tag, input int cnt,
                       input int first, input int exp_off);
    check(cnt == ((exp_off != 0) ? 1 : 0), req, {tag, " pulse count"}, cnt,
          (exp_off != 0) ? 1 : 0);
    if (exp_off != 0)
      check(first == exp_off, req, {tag, " pulse offset"}, first, exp_off);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200_000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt [3];
    int first [3];
    int start;

    // R10: outputs low while held in reset
    repeat (5) begin
      @(negedge clk);
      check({evt_resume, evt_idle, evt_attach} == 3'b000, 10, "reset outputs",
            {evt_resume, evt_idle, evt_attach}, 0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      dp = VECS[v].dp; dm = VECS[v].dm;
      host_en = VECS[v].host; resume_en = VECS[v].resen;
      start = cyc;
      observe(int'(VECS[v].hold), start, cnt, first);
      judge(int'(VECS[v].req), $sformatf("row %0d resume", v), cnt[0], first[0], int'(VECS[v].off_res));
      judge(int'(VECS[v].req), $sformatf("row %0d idle", v), cnt[1], first[1], int'(VECS[v].off_idle));
      judge(int'(VECS[v].req), $sformatf("row %0d attach", v), cnt[2], first[2], int'(VECS[v].off_att));
    end

    // R10: reset in the middle of a K period, then K held across release
    dp = 1'b0; dm = 1'b1; host_en = 1'b0; resume_en = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < int'(TS) + 10; k++) begin
      @(negedge clk);
      check({evt_resume, evt_idle, evt_attach} == 3'b000, 10, "outputs in mid-run reset",
            {evt_resume, evt_idle, evt_attach}, 0);
    end
    rst_n = 1'b1;
    start = cyc;
    observe(int'(TS) + 20, start, cnt, first);
    judge(10, "resume after reset", cnt[0], first[0], int'(TS + LAT));
    judge(10, "idle after reset", cnt[1], first[1], 0);

    // R2/R4: enable dropped mid-K clears the count; re-enable restarts timing
    resume_en = 1'b0;
    repeat (4) @(negedge clk);
    resume_en = 1'b1;
    start = cyc;
    observe(int'(TS) + 10, start, cnt, first);
    judge(4, "resume after re-enable", cnt[0], first[0], int'(TS));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule